// File: doc/BRIEF.md
# Retimer Power-Up Configuration Handshake Registers

This block is the device side of a one-time handshake through which a host asks an embedded controller to configure two retimers. Each retimer has four lanes. The host writes a control word that carries a start flag and a 2-bit forward-error-correction request for each of the eight lanes. The block accepts that request only once per power-up. It runs a fixed-length configuration period, modelled as a busy counter, and then raises a completion flag.

Completion and the outcome are reported separately. After completion, each retimer has a status word that holds an error group code and the lane mode the retimer was set to. A version word reports which controller firmware is present. For firmware whose major number is below 3, the block has no request mechanism: it marks itself complete straight after reset and ignores start writes. The block also drives the FEC code in force on every lane. A lane that does not run at 25G gets no FEC.

Top module: `hs_init_regs`

## Requirements
- R1: After reset with a firmware major of 3 or more, the control word at 0x1000, both status words and `fec_applied` all read 0, and `cfg_done` is low.
- R2: A write to 0x1000 with bit 1 set is accepted when firmware major is 3 or more and neither start nor done is set. Acceptance sets start (bit 1) and latches bits 23:8 as eight 2-bit FEC requests, lane A0 in bits 9:8 up to lane B3 in bits 23:22. These bits read back exactly as written.
- R3: Done (bit 0 of 0x1000, also the `cfg_done` port) rises exactly BUSY_CYCLES clock edges after the accepting edge. Once set, it stays set until reset.
- R4: Once start or done is set, no later write to 0x1000 changes the control word until the next reset.
- R5: A write to 0x1000 with bit 1 clear changes nothing and starts no configuration.
- R6: If the major number (bits 31:28 of `fw_version`) is below 3, and this includes a version of zero, done is set on the first clock edge after reset. Start writes are then ignored and the FEC fields stay 0.
- R7: The status words at 0x1020 (retimer A) and 0x1024 (retimer B) read 0 before done. After done they read the error group in bits 15:8 (0 = OK) and the target mode ID in bits 7:0. Done is set even when a group code is non-zero.
- R8: 0x1004 reads `fw_version`. Writes to 0x1004, 0x1020 and 0x1024 have no effect, and unmapped addresses read 0.
- R9: `fec_applied` is 0 until done. After done, lane i (bits 2i+1:2i, in A0..A3 then B0..B3 order) carries its latched request if the lane runs at 25G under its retimer's mode, and 0 otherwise. Mode IDs are 0 reset (no lanes), 1 4x10G, 2 4x25G, 3 two 25G lanes (0,1), 4 two 25G lanes (0,1) plus two 10G lanes, and 5 one 25G lane (0). FEC codes are 0 none, 1 Fire Code and 2 Reed-Solomon.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fw_version | input | 32 | Static firmware version word |
| tgt_mode_a | input | 8 | Target mode ID for retimer A |
| tgt_mode_b | input | 8 | Target mode ID for retimer B |
| cfg_err_a | input | 8 | Error group produced by configuring retimer A |
| cfg_err_b | input | 8 | Error group produced by configuring retimer B |
| cfg_done | output | 1 | Configuration complete |
| fec_applied | output | 16 | FEC code in force per lane, 2 bits per lane |

## Verification
A wrong start or done state is visible on the next read of 0x1000. A lost one-shot guard shows as a changed FEC field on the read right after a second write. A wrong busy count moves the edge of `cfg_done` by the same number of cycles, and the bench samples that edge on both sides. Lane mapping errors show only after done, on `fec_applied`, so each mode ID is paired with a distinct per-lane FEC pattern. That pairing means a swapped lane or retimer changes the value on the port.

// File: rtl/hs_init_pkg.sv
package hs_init_pkg;
  localparam int ADDR_W       = 16;
  localparam int DATA_W       = 32;
  localparam int LANES_PER_RT = 4;
  localparam int NUM_RT       = 2;
  localparam int FEC_W        = 2;
  localparam int RT_FEC_BITS  = LANES_PER_RT * FEC_W;
  localparam int FEC_BITS     = NUM_RT * RT_FEC_BITS;
  localparam int FEC_LSB      = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 16'h1000;
  localparam logic [ADDR_W-1:0] A_VER   = 16'h1004;
  localparam logic [ADDR_W-1:0] A_STS_A = 16'h1020;
  localparam logic [ADDR_W-1:0] A_STS_B = 16'h1024;

  typedef enum logic [7:0] {
    RT_OFF       = 8'd0,
    RT_4X10      = 8'd1,
    RT_4X25      = 8'd2,
    RT_2X25      = 8'd3,
    RT_2X25_2X10 = 8'd4,
    RT_1X25      = 8'd5
  } rt_mode_e;

  // Which lanes of a retimer run at 25G for a given mode ID
  function automatic logic [LANES_PER_RT-1:0] lanes_25g(input logic [7:0] mode);
    case (mode)
      RT_4X25:      lanes_25g = 4'b1111;
      RT_2X25:      lanes_25g = 4'b0011;
      RT_2X25_2X10: lanes_25g = 4'b0011;
      RT_1X25:      lanes_25g = 4'b0001;
      default:      lanes_25g = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/hs_init_ctrl.sv
module hs_init_ctrl
  import hs_init_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                legacy,
  input  logic                wr_hit,
  input  logic                req_start,
  input  logic [FEC_BITS-1:0] req_fec,
  output logic                start_q,
  output logic                done_q,
  output logic [FEC_BITS-1:0] fec_q
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic                start_d, done_d, busy_q, busy_d, accept;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [FEC_BITS-1:0] fec_d;

  always_comb begin
    accept  = wr_hit && req_start && !legacy && !start_q && !done_q;
    start_d = start_q;
    done_d  = done_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    fec_d   = fec_q;
    if (legacy && !done_q) begin
      done_d = 1'b1;
    end else if (accept) begin
      start_d = 1'b1;
      fec_d   = req_fec;
      busy_d  = 1'b1;
      cnt_d   = CNT_W'(BUSY_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      fec_q   <= '0;
    end else begin
      start_q <= start_d;
      done_q  <= done_d;
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      fec_q   <= fec_d;
    end
  end
endmodule

// File: rtl/hs_lane_fec.sv
module hs_lane_fec
  import hs_init_pkg::*;
(
  input  logic [7:0]             mode,
  input  logic                   enable,
  input  logic [RT_FEC_BITS-1:0] fec_req,
  output logic [RT_FEC_BITS-1:0] fec_out
);
  logic [LANES_PER_RT-1:0] fast;
  assign fast = lanes_25g(mode);

  for (genvar l = 0; l < LANES_PER_RT; l++) begin : g_lane
    assign fec_out[l*FEC_W +: FEC_W] =
      (enable && fast[l]) ? fec_req[l*FEC_W +: FEC_W] : '0;
  end
endmodule

// File: rtl/hs_init_regs.sv
module hs_init_regs
  import hs_init_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [DATA_W-1:0]   fw_version,
  input  logic [7:0]          tgt_mode_a,
  input  logic [7:0]          tgt_mode_b,
  input  logic [7:0]          cfg_err_a,
  input  logic [7:0]          cfg_err_b,
  output logic                cfg_done,
  output logic [FEC_BITS-1:0] fec_applied
);
  logic                legacy, start_q, done_q;
  logic [FEC_BITS-1:0] fec_q;
  logic [7:0]          mode_arr [NUM_RT];
  logic [7:0]          err_arr  [NUM_RT];
  logic [DATA_W-1:0]   sts_arr  [NUM_RT];

  assign legacy = (fw_version[31:28] < 4'd3);

  hs_init_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .legacy    (legacy),
    .wr_hit    (bus_wr && (bus_addr == A_CTRL)),
    .req_start (bus_wdata[1]),
    .req_fec   (bus_wdata[FEC_LSB +: FEC_BITS]),
    .start_q   (start_q),
    .done_q    (done_q),
    .fec_q     (fec_q)
  );

  assign mode_arr[0] = tgt_mode_a;
  assign mode_arr[1] = tgt_mode_b;
  assign err_arr[0]  = cfg_err_a;
  assign err_arr[1]  = cfg_err_b;

  for (genvar r = 0; r < NUM_RT; r++) begin : g_rt
    hs_lane_fec u_lane (
      .mode    (mode_arr[r]),
      .enable  (done_q),
      .fec_req (fec_q[r*RT_FEC_BITS +: RT_FEC_BITS]),
      .fec_out (fec_applied[r*RT_FEC_BITS +: RT_FEC_BITS])
    );
    assign sts_arr[r] = done_q ? {16'h0, err_arr[r], mode_arr[r]} : '0;
  end

  assign cfg_done = done_q;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {8'h0, fec_q, 6'h0, start_q, done_q};
      A_VER:   bus_rdata = fw_version;
      A_STS_A: bus_rdata = sts_arr[0];
      A_STS_B: bus_rdata = sts_arr[1];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hs_init_regs_chk.sv
module hs_init_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_done,
  input logic        start_q,
  input logic [15:0] fec_q,
  input logic [31:0] fw_version,
  input logic [15:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic [15:0] fec_applied
);
  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);
  // R3
  done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_done) && fw_version[31:28] >= 4'd3) |-> start_q);
  // R4
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> start_q);
  // R4
  fec_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q || cfg_done) |=> $stable(fec_q));
  // R6
  legacy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_version[31:28] < 4'd3) |=> cfg_done);
  // R7
  status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_done && (bus_addr == 16'h1020 || bus_addr == 16'h1024)) |-> bus_rdata == 32'h0);
  // R9
  fec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> fec_applied == 16'h0);
endmodule

bind hs_init_regs hs_init_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_done    (cfg_done),
  .start_q     (start_q),
  .fec_q       (fec_q),
  .fw_version  (fw_version),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .fec_applied (fec_applied)
);

// File: tb/sim_hs_init_regs.sv
module sim_hs_init_regs;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [31:0] fw_version = 32'h3120_0000;
  logic [7:0]  tgt_mode_a = 8'd2, tgt_mode_b = 8'd2, cfg_err_a = 8'd0, cfg_err_b = 8'd0;
  logic        cfg_done;
  logic [15:0] fec_applied;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_init_regs #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fw_version(fw_version),
    .tgt_mode_a(tgt_mode_a), .tgt_mode_b(tgt_mode_b), .cfg_err_a(cfg_err_a),
    .cfg_err_b(cfg_err_b), .cfg_done(cfg_done), .fec_applied(fec_applied));

  // A0=RS A1=FC A2=none A3=RS B0=FC B1=RS B2=none B3=FC
  localparam logic [15:0] PAT  = 16'h4986;
  localparam logic [15:0] PAT2 = 16'h1234;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench-side lane table
  function automatic logic [15:0] exp_fec(input logic [7:0] ma, input logic [7:0] mb, input logic [15:0] f);
    logic [15:0] r = 16'h0;
    logic [3:0] ea, eb;
    ea = (ma == 2) ? 4'hF : (ma == 3 || ma == 4) ? 4'h3 : (ma == 5) ? 4'h1 : 4'h0;
    eb = (mb == 2) ? 4'hF : (mb == 3 || mb == 4) ? 4'h3 : (mb == 5) ? 4'h1 : 4'h0;
    for (int i = 0; i < 4; i++) begin
      if (ea[i]) r[2*i +: 2] = f[2*i +: 2];
      if (eb[i]) r[8+2*i +: 2] = f[8+2*i +: 2];
    end
    return r;
  endfunction

  task automatic do_reset(input logic [31:0] ver, input logic [7:0] ma, input logic [7:0] mb,
                          input logic [7:0] ea, input logic [7:0] eb);
    @(negedge clk);
    rst_n = 1'b0; fw_version = ver; tgt_mode_a = ma; tgt_mode_b = mb;
    cfg_err_a = ea; cfg_err_b = eb; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset(32'h3120_0000, 8'd2, 8'd2, 8'd0, 8'd0);
    rd(16'h1000, d); check("R1", "ctrl after reset", d, 32'h0);
    rd(16'h1020, d); check("R1", "status A after reset", d, 32'h0);
    rd(16'h1024, d); check("R1", "status B after reset", d, 32'h0);
    check("R1", "cfg_done after reset", {31'h0, cfg_done}, 32'h0);
    check("R1", "fec_applied after reset", {16'h0, fec_applied}, 32'h0);
  endtask

  task automatic t_accept_and_timing();
    logic [31:0] d;
    do_reset(32'h3120_0000, 8'd2, 8'd2, 8'd0, 8'd0);
    wr(16'h1000, {8'h0, PAT, 8'h02});
    rd(16'h1000, d); check("R2", "ctrl after accept", d, {8'h0, PAT, 8'h02});
    check("R9", "fec_applied while busy", {16'h0, fec_applied}, 32'h0);
    idle(BUSY - 1);
    check("R3", "done one cycle early", {31'h0, cfg_done}, 32'h0);
    idle(1);
    check("R3", "done at busy end", {31'h0, cfg_done}, 32'h1);
    rd(16'h1000, d); check("R3", "ctrl after done", d, {8'h0, PAT, 8'h03});
    rd(16'h1020, d); check("R7", "status A after done", d, 32'h0000_0002);
    check("R9", "fec_applied 4x25G both", {16'h0, fec_applied}, {16'h0, exp_fec(8'd2, 8'd2, PAT)});
    wr(16'h1000, {8'h0, PAT2, 8'h02});
    rd(16'h1000, d); check("R4", "second write after done", d, {8'h0, PAT, 8'h03});
  endtask

  task automatic t_write_while_busy();
    logic [31:0] d;
    do_reset(32'h3120_0000, 8'd2, 8'd2, 8'd0, 8'd0);
    wr(16'h1000, {8'h0, PAT, 8'h02});
    wr(16'h1000, {8'h0, PAT2, 8'h02});
    rd(16'h1000, d); check("R4", "write during busy", d, {8'h0, PAT, 8'h02});
    idle(BUSY);
    check("R4", "busy not restarted", {31'h0, cfg_done}, 32'h1);
  endtask

  task automatic t_no_start();
    logic [31:0] d;
    do_reset(32'h3120_0000, 8'd2, 8'd2, 8'd0, 8'd0);
    wr(16'h1000, {8'h0, PAT, 8'h00});
    rd(16'h1000, d); check("R5", "write without start", d, 32'h0);
    idle(BUSY + 2);
    check("R5", "no done without start", {31'h0, cfg_done}, 32'h0);
  endtask

  task automatic t_legacy(input logic [31:0] ver);
    logic [31:0] d;
    do_reset(ver, 8'd2, 8'd1, 8'd0, 8'd0);
    idle(1);
    check("R6", "legacy done after reset", {31'h0, cfg_done}, 32'h1);
    wr(16'h1000, {8'h0, PAT, 8'h02});
    rd(16'h1000, d); check("R6", "legacy start ignored", d, 32'h1);
    check("R6", "legacy fec_applied", {16'h0, fec_applied}, 32'h0);
    rd(16'h1020, d); check("R7", "legacy status A", d, 32'h0000_0002);
  endtask

  task automatic t_error_mixed();
    logic [31:0] d;
    do_reset(32'h3000_0000, 8'd4, 8'd1, 8'h05, 8'h00);
    wr(16'h1000, {8'h0, 16'hAAAA, 8'h02});
    idle(BUSY);
    check("R7", "done despite error", {31'h0, cfg_done}, 32'h1);
    rd(16'h1020, d); check("R7", "status A with error", d, 32'h0000_0504);
    rd(16'h1024, d); check("R7", "status B ok", d, 32'h0000_0001);
    check("R9", "fec_applied 2x25+2x10 / 4x10", {16'h0, fec_applied}, {16'h0, exp_fec(8'd4, 8'd1, 16'hAAAA)});
  endtask

  task automatic t_one_lane();
    do_reset(32'h4000_0000, 8'd5, 8'd3, 8'h00, 8'h00);
    wr(16'h1000, {8'h0, 16'h5555, 8'h02});
    idle(BUSY);
    check("R9", "fec_applied 1x25 / 2x25", {16'h0, fec_applied}, {16'h0, exp_fec(8'd5, 8'd3, 16'h5555)});
  endtask

  task automatic t_read_only();
    logic [31:0] d;
    do_reset(32'h3450_0000, 8'd2, 8'd3, 8'd0, 8'd0);
    wr(16'h1004, 32'hFFFF_FFFF);
    rd(16'h1004, d); check("R8", "version after write", d, 32'h3450_0000);
    wr(16'h1020, 32'hFFFF_FFFF);
    wr(16'h1024, 32'hFFFF_FFFF);
    rd(16'h1020, d); check("R8", "status A after write", d, 32'h0);
    rd(16'h1000, d); check("R8", "ctrl after ro writes", d, 32'h0);
    rd(16'h1008, d); check("R8", "unmapped read", d, 32'h0);
  endtask

  initial begin
    t_reset_state();
    t_accept_and_timing();
    t_write_while_busy();
    t_no_start();
    t_legacy(32'h2100_0000);
    t_legacy(32'h0000_0000);
    t_error_mixed();
    t_one_lane();
    t_read_only();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule